// File: doc/BRIEF.md
# Two-Bank Maskable Interrupt Controller

The block collects level-sensitive interrupt sources into two banks that work side by side. One bank feeds the ordinary processor interrupt line and the other feeds the fast interrupt line. Each bank keeps its own enable mask and presents two views of its sources to software: the unmasked source levels, and the source levels gated by the mask. Each bank drives its processor line high whenever any enabled source is active.

Software never writes a mask as a whole word. Each bank has a set register and a clear register at separate addresses. A write to the set register turns on every mask bit that is 1 in the data. A write to the clear register turns off every mask bit that is 1 in the data. Because the two banks keep fully separate register sets, code running at one interrupt level can change its mask without a read-modify-write race against the other. The status views are read-only and the set/clear registers are write-only. An access in the wrong direction sets a sticky error flag, and only reset clears that flag.

Top module: `intc_dual_bank`

## Requirements
- R1: A read of a bank's masked view (address offset 0) returns that bank's source vector ANDed with its enable mask, in the same cycle as the request.
- R2: A read of a bank's raw view (offset 1) returns that bank's source vector with no masking.
- R3: A write to a bank's enable-set register (offset 2) ORs the write data into that bank's mask and clears no bit.
- R4: A write to a bank's enable-clear register (offset 3) clears every mask bit that is 1 in the write data and sets no bit.
- R5: Address bit 2 selects the bank (0 = IRQ, 1 = FIQ). An access to one bank never changes the other bank's mask.
- R6: Each bank's output is a register that holds the OR of (source AND mask). The register is loaded on every clock edge with the mask value that the same edge commits, so a mask write changes the output on its own edge.
- R7: A write to offset 0 or 1, or a read of offset 2 or 3, is an access error. It sets `access_err` on the next edge, it leaves both masks unchanged, and the read returns 0.
- R8: After reset, both masks are zero, both outputs are low and `access_err` is low.
- R9: Once `access_err` is set, it stays set through any later access until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src | input | 32 | Source levels of the normal interrupt bank |
| fiq_src | input | 32 | Source levels of the fast interrupt bank |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Bit 2 selects the bank, bits 1:0 select the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, combinational, 0 when no legal read is in progress |
| irq_out | output | 1 | Registered normal interrupt request |
| fiq_out | output | 1 | Registered fast interrupt request |
| access_err | output | 1 | Sticky wrong-direction access flag |

## Verification
The assertions check on every cycle that each output equals the OR of the previous cycle's sources gated by the current mask. They also check that set writes only add bits and clear writes only remove bits, that a bank's mask stays fixed when the bank is not written, that the error flag rises after an illegal access and then holds, and that the masked read path matches the mask. The bench scenarios cover the rest. Walking-one sweeps set and then clear each mask bit of both banks and check the other bank after each step. Illegal accesses are checked at the ports to confirm they leave the masks alone and read back zero. Further scenarios check the exact cycle on which an output responds to a mask write compared with a source change.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned REG_AW  = 3;
  localparam int unsigned N_BANKS = 2;

  typedef enum logic [1:0] {
    OFS_MASKED = 2'd0,
    OFS_RAW    = 2'd1,
    OFS_EN_SET = 2'd2,
    OFS_EN_CLR = 2'd3
  } reg_ofs_e;

  typedef enum logic {
    BANK_IRQ = 1'b0,
    BANK_FIQ = 1'b1
  } bank_e;

  typedef struct packed {
    logic set_we;
    logic clr_we;
    logic rd_masked;
    logic rd_raw;
  } bank_cmd_t;

  // Offsets with bit 1 set are write-only and the others are read-only.
  function automatic logic is_wrong_dir(input logic wr, input logic [1:0] ofs);
    return wr != ofs[1];
  endfunction
endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
(
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [REG_AW-1:0]          req_addr,
  output bank_cmd_t [N_BANKS-1:0]    cmd,
  output logic                       err_event
);
  logic [1:0] ofs;
  logic       dir_bad;

  assign ofs       = req_addr[1:0];
  assign dir_bad   = is_wrong_dir(req_write, ofs);
  assign err_event = req_valid && dir_bad;

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank_dec
    logic hit;
    assign hit              = req_valid && !dir_bad && (req_addr[2] == g[0]);
    assign cmd[g].set_we    = hit &&  req_write && (ofs == OFS_EN_SET);
    assign cmd[g].clr_we    = hit &&  req_write && (ofs == OFS_EN_CLR);
    assign cmd[g].rd_masked = hit && !req_write && (ofs == OFS_MASKED);
    assign cmd[g].rd_raw    = hit && !req_write && (ofs == OFS_RAW);
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [W-1:0] wdata,
  input  bank_cmd_t    cmd,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] masked,
  output logic         cpu_int_q
);
  function automatic logic [W-1:0] next_mask(input logic [W-1:0] cur,
                                             input logic [W-1:0] d,
                                             input logic set, input logic clr);
    logic [W-1:0] r;
    r = cur;
    if (set) r = r | d;
    if (clr) r = r & ~d;
    return r;
  endfunction

  function automatic logic [W-1:0] gate(input logic [W-1:0] s, input logic [W-1:0] m);
    return s & m;
  endfunction

  logic [W-1:0] mask_d;

  assign mask_d = next_mask(mask_q, wdata, cmd.set_we, cmd.clr_we);
  assign masked = gate(src, mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      cpu_int_q <= 1'b0;
    end else begin
      mask_q    <= mask_d;
      cpu_int_q <= |gate(src, mask_d);
    end
  end
endmodule

// File: rtl/intc_sticky_flag.sv
module intc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (event_i) flag_q <= 1'b1;
  end
endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
  import intc_pkg::*;
#(
  parameter int unsigned SRC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  irq_src,
  input  logic [SRC_W-1:0]  fiq_src,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [REG_AW-1:0] req_addr,
  input  logic [SRC_W-1:0]  req_wdata,
  output logic [SRC_W-1:0]  rsp_rdata,
  output logic              irq_out,
  output logic              fiq_out,
  output logic              access_err
);
  bank_cmd_t [N_BANKS-1:0]              cmd;
  logic                                 err_event;
  logic [N_BANKS-1:0][SRC_W-1:0]        src_all;
  logic [N_BANKS-1:0][SRC_W-1:0]        mask_all;
  logic [N_BANKS-1:0][SRC_W-1:0]        masked_all;
  logic [N_BANKS-1:0][SRC_W-1:0]        rd_part;
  logic [N_BANKS-1:0]                   int_all;
  logic [N_BANKS-1:0]                   bank_wr;

  // Named internal events for the checker
  logic [SRC_W-1:0] irq_mask;
  logic [SRC_W-1:0] fiq_mask;

  assign src_all[BANK_IRQ] = irq_src;
  assign src_all[BANK_FIQ] = fiq_src;

  intc_decode u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .cmd       (cmd),
    .err_event (err_event)
  );

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    intc_bank #(.W(SRC_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (src_all[g]),
      .wdata     (req_wdata),
      .cmd       (cmd[g]),
      .mask_q    (mask_all[g]),
      .masked    (masked_all[g]),
      .cpu_int_q (int_all[g])
    );
    assign rd_part[g] = ({SRC_W{cmd[g].rd_masked}} & masked_all[g])
                      | ({SRC_W{cmd[g].rd_raw}}    & src_all[g]);
    assign bank_wr[g] = cmd[g].set_we | cmd[g].clr_we;
  end

  always_comb begin
    rsp_rdata = '0;
    for (int b = 0; b < N_BANKS; b++) rsp_rdata = rsp_rdata | rd_part[b];
  end

  intc_sticky_flag u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .event_i (err_event),
    .flag_q  (access_err)
  );

  assign irq_out  = int_all[BANK_IRQ];
  assign fiq_out  = int_all[BANK_FIQ];
  assign irq_mask = mask_all[BANK_IRQ];
  assign fiq_mask = mask_all[BANK_FIQ];
endmodule

// File: rtl/intc_dual_bank_chk.sv
module intc_dual_bank_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] irq_src,
  input logic [W-1:0] fiq_src,
  input logic         req_valid,
  input logic         req_write,
  input logic [2:0]   req_addr,
  input logic [W-1:0] req_wdata,
  input logic [W-1:0] rsp_rdata,
  input logic         irq_out,
  input logic         fiq_out,
  input logic         access_err,
  input logic [W-1:0] irq_mask,
  input logic [W-1:0] fiq_mask,
  input logic         err_event,
  input logic [1:0]   bank_wr
);
  logic irq_set_wr, irq_clr_wr;
  assign irq_set_wr = req_valid && req_write && req_addr == 3'd2;
  assign irq_clr_wr = req_valid && req_write && req_addr == 3'd3;

  AST_IRQ_OUT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |($past(irq_src) & irq_mask)); // R6
  AST_FIQ_OUT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out == |($past(fiq_src) & fiq_mask)); // R6
  AST_SET_ADDS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_wr |=> ((irq_mask & $past(req_wdata)) == $past(req_wdata))
                   && (($past(irq_mask) & ~irq_mask) == '0)); // R3
  AST_CLR_DROPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_wr |=> ((irq_mask & $past(req_wdata)) == '0)
                   && ((irq_mask & ~$past(irq_mask)) == '0)); // R4
  AST_IRQ_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr[0] |=> $stable(irq_mask)); // R5
  AST_FIQ_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr[1] |=> $stable(fiq_mask)); // R5
  AST_ERR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |=> access_err); // R7
  AST_ERR_NO_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |-> bank_wr == 2'b00); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |=> access_err); // R9
  AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 3'd0) |-> rsp_rdata == (irq_src & irq_mask)); // R1
endmodule

bind intc_dual_bank intc_dual_bank_chk #(.W(SRC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_src    (irq_src),
  .fiq_src    (fiq_src),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .rsp_rdata  (rsp_rdata),
  .irq_out    (irq_out),
  .fiq_out    (fiq_out),
  .access_err (access_err),
  .irq_mask   (irq_mask),
  .fiq_mask   (fiq_mask),
  .err_event  (err_event),
  .bank_wr    (bank_wr)
);

// File: tb/test_intc_dual_bank.sv
`timescale 1ns/1ps
module test_intc_dual_bank;
  localparam int W = 32;
  localparam logic [1:0] O_MSK = 2'd0, O_RAW = 2'd1, O_SET = 2'd2, O_CLR = 2'd3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [W-1:0] irq_src = '0, fiq_src = '0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]   req_addr = '0;
  logic [W-1:0] req_wdata = '0;
  logic [W-1:0] rsp_rdata;
  logic         irq_out, fiq_out, access_err;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [W-1:0] mdl [2];

  intc_dual_bank #(.SRC_W(W)) i_intc_dual_bank (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .fiq_src(fiq_src),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq_out(irq_out),
    .fiq_out(fiq_out), .access_err(access_err)
  );

  function automatic logic [W-1:0] src_of(input int b);
    return (b == 0) ? irq_src : fiq_src;
  endfunction

  function automatic logic out_of(input int b);
    return (b == 0) ? irq_out : fiq_out;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int b, input logic [1:0] ofs, input logic [W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = {b[0], ofs}; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int b, input logic [1:0] ofs, output logic [W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {b[0], ofs};
    #1 d = rsp_rdata;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_m(input int b, input logic [W-1:0] d);
    wr(b, O_SET, d); mdl[b] = mdl[b] | d;
  endtask

  task automatic clr_m(input int b, input logic [W-1:0] d);
    wr(b, O_CLR, d); mdl[b] = mdl[b] & ~d;
  endtask

  task automatic check_bank(input int b, input string tag);
    logic [W-1:0] v;
    rd(b, O_MSK, v); chk({tag, " R1 masked"}, v, src_of(b) & mdl[b]);
    rd(b, O_RAW, v); chk({tag, " R2 raw"}, v, src_of(b));
    chk({tag, " R6 out"}, W'(out_of(b)), W'(|(src_of(b) & mdl[b])));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mdl[0] = '0; mdl[1] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    irq_src = '1; fiq_src = '1;
    do_reset();
    // R8 reset state
    @(negedge clk);
    chk("R8 irq_out", W'(irq_out), '0);
    chk("R8 fiq_out", W'(fiq_out), '0);
    chk("R8 access_err", W'(access_err), '0);
    rd(0, O_MSK, v); chk("R8 irq mask zero", v, '0);
    rd(1, O_MSK, v); chk("R8 fiq mask zero", v, '0);

    // Walking-one sweeps over both banks (R3, R4, R5, R6)
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < W; i++) begin
        set_m(b, W'(1) << i);
        chk("R6 out after set", W'(out_of(b)), W'(1));
        rd(b, O_MSK, v); chk("R3 set walk", v, mdl[b]);
        rd(1 - b, O_MSK, v); chk("R5 other bank after set", v, mdl[1 - b]);
      end
      for (int i = 0; i < W; i++) begin
        clr_m(b, W'(1) << i);
        chk("R6 out after clear", W'(out_of(b)), W'(mdl[b] != '0));
        rd(b, O_MSK, v); chk("R4 clear walk", v, mdl[b]);
        rd(1 - b, O_MSK, v); chk("R5 other bank after clear", v, mdl[1 - b]);
      end
    end

    // Mixed patterns (R1, R2, R3, R4)
    @(negedge clk); irq_src = 32'hA5A5_A5A5; fiq_src = 32'h3C3C_0FF0;
    set_m(0, 32'hFFFF_0000); set_m(1, 32'h0000_FFFF);
    check_bank(0, "pat irq"); check_bank(1, "pat fiq");
    set_m(0, 32'h0000_0101); check_bank(0, "R3 or-in");
    clr_m(0, 32'hF0F0_0100); check_bank(0, "R4 partial clear");
    clr_m(1, 32'h0000_0FF0); check_bank(1, "R4 fiq clear");
    @(negedge clk); irq_src = 32'h0000_0000; fiq_src = 32'h8000_0001;
    @(negedge clk);
    check_bank(0, "pat2 irq"); check_bank(1, "pat2 fiq");

    // R6 timing: mask edge vs source edge
    clr_m(0, '1); clr_m(1, '1);
    @(negedge clk); irq_src = 32'h0000_0010;
    @(negedge clk); chk("R6 masked source low", W'(irq_out), '0);
    set_m(0, 32'h0000_0010);
    chk("R6 same-edge response to set", W'(irq_out), W'(1));
    @(negedge clk); irq_src = '0;
    #1 chk("R6 registered before edge", W'(irq_out), W'(1));
    @(negedge clk); chk("R6 source drop after edge", W'(irq_out), '0);
    @(negedge clk); irq_src = 32'h0000_0010;
    @(negedge clk); chk("R6 source rise", W'(irq_out), W'(1));
    clr_m(0, 32'h0000_0010);
    chk("R6 same-edge response to clear", W'(irq_out), '0);
    chk("R7 no false error", W'(access_err), '0);

    // R7 wrong-direction accesses
    @(negedge clk); irq_src = '1; fiq_src = '1;
    set_m(0, 32'h0000_00F0); set_m(1, 32'h0F00_0000);
    wr(0, O_MSK, '1);
    chk("R7 error raised", W'(access_err), W'(1));
    rd(0, O_MSK, v); chk("R7 write to status ignored", v, mdl[0]);
    wr(1, O_RAW, '1);
    rd(1, O_MSK, v); chk("R7 write to raw ignored", v, mdl[1]);
    rd(0, O_SET, v); chk("R7 read of set returns 0", v, '0);
    rd(1, O_CLR, v); chk("R7 read of clear returns 0", v, '0);
    rd(0, O_MSK, v); chk("R7 masks intact", v, mdl[0]);

    // R9 sticky until reset
    set_m(1, 32'h0000_0001); clr_m(1, 32'h0000_0001);
    chk("R9 flag held", W'(access_err), W'(1));
    do_reset();
    @(negedge clk);
    chk("R9 flag cleared by reset", W'(access_err), '0);
    rd(0, O_MSK, v); chk("R8 mask cleared by reset", v, '0);
    chk("R8 irq_out after reset", W'(irq_out), '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule